// File: doc/BRIEF.md
# Programmable Control Sequencer

This block is a small instruction-driven engine that produces the timing of a sensor's control lines. It holds a program of 12-bit words in an internal instruction store and executes one command per clock. Eight commands exist. One sets the selected row. Three each set or clear one switch in one of three switch groups. One produces a timed pause. Two form a counted loop. The last is a two-word command that writes a 21-bit value to a converter control register. The analog parts being controlled are outside the block; they appear here only as output registers.

The store is loaded through a plain write port, usually while the block is in reset or stopped. Raising `run` starts execution from address 0. Lowering `run` freezes every output and returns the program counter to 0, so the next rise of `run` restarts the program from the beginning.

Top module: `sensor_ctrl_seq`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `row_sel`, `amp_sw`, `pix_sw`, `aux_sw`, `cfg_data` and `cfg_we` are all zero, and the program counter is 0.
- R2: Each word carries its opcode in bits [11:9] and its body in bits [8:0]. The opcodes are: 0 pause, 1 row, 2 amplifier switch, 3 pixel switch, 4 auxiliary switch, 5 loop load, 6 loop jump, 7 register write.
- R3: The row command sets `row_sel` to its 9-bit body. The value is visible after the edge that executes the command, and the command takes one cycle.
- R4: A switch command sets the bit of its group whose index is body[8:1] to the value in body bit 0. It leaves every other switch bit unchanged and takes one cycle. An index equal to or above the group width has no effect. At most one switch bit changes per cycle.
- R5: A pause with body n occupies n+1 cycles, so n=0 takes one cycle. No output changes during the pause.
- R6: Loop load copies its body into a 9-bit loop counter. Loop jump reads its target from body[6:0]. If the counter is non-zero, it branches to the target and decrements the counter. If the counter is zero, execution continues at the next address. A loop loaded with c therefore runs its body c+1 times.
- R7: The register write uses two consecutive words. After the second word executes, `cfg_we` is high for exactly one cycle and `cfg_data` is {first word body, all 12 bits of the second word}. `cfg_we` is never high for two cycles in a row.
- R8: While `run` is low, no command executes, every output holds its value, `cfg_we` stays low, and the program counter returns to 0.
- R9: A word presented on the write port with `imem_we` high is stored at `imem_waddr` on the clock edge. The next execution of that address uses the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Execute when high; hold and rewind to address 0 when low |
| imem_we | input | 1 | Instruction store write enable |
| imem_waddr | input | AW (7) | Instruction store write address |
| imem_wdata | input | 12 | Instruction word to store |
| row_sel | output | 9 | Selected row |
| amp_sw | output | SW_W (8) | Amplifier switch group |
| pix_sw | output | SW_W (8) | Pixel switch group |
| aux_sw | output | SW_W (8) | Auxiliary switch group |
| cfg_we | output | 1 | One-cycle converter register write strobe |
| cfg_data | output | 21 | Converter register write value |

## Verification
A short program uses every opcode. Its output trace is compared cycle by cycle against a table. In that trace, pause length is told apart by the exact cycle on which the next switch change lands. Loop trip count is told apart by the number of set-and-clear pulses on one auxiliary switch. The fall-through of a jump taken with an empty counter is told apart from a branch by the command that follows it. The same program contains an out-of-range switch index, which shows that such an index is ignored. It also contains a register write whose two halves use distinct bit patterns, so that a swap of the halves or a missed latch shows up in `cfg_data`. Directed tests then stop and restart with `run` and patch a word while the block is stopped. The restart tells a rewind to address 0 apart from a resume at the old address. The patched word tells the new word apart from the old one. A mid-run reset is also checked.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int OPC_W   = 3;
    localparam int BODY_W  = 9;
    localparam int WORD_W  = OPC_W + BODY_W;
    localparam int SWIDX_W = BODY_W - 1;
    localparam int CFG_W   = BODY_W + WORD_W;
    localparam int NGROUP  = 3;

    typedef enum logic [OPC_W-1:0] {
        OP_PAUSE   = 3'd0,
        OP_ROW     = 3'd1,
        OP_SW_AMP  = 3'd2,
        OP_SW_PIX  = 3'd3,
        OP_SW_AUX  = 3'd4,
        OP_LOOPSET = 3'd5,
        OP_LOOPJMP = 3'd6,
        OP_CFGWR   = 3'd7
    } opcode_e;

    typedef enum logic [1:0] {
        ST_ISSUE = 2'd0,
        ST_PAUSE = 2'd1,
        ST_CFG2  = 2'd2
    } state_e;

    typedef struct packed {
        opcode_e              op;
        logic [BODY_W-1:0]    body;
        logic [SWIDX_W-1:0]   sw_idx;
        logic                 sw_val;
    } instr_t;

    function automatic instr_t split_word(input logic [WORD_W-1:0] w);
        instr_t d;
        d.op     = opcode_e'(w[WORD_W-1:BODY_W]);
        d.body   = w[BODY_W-1:0];
        d.sw_idx = w[BODY_W-1:1];
        d.sw_val = w[0];
        return d;
    endfunction
endpackage

// File: rtl/seq_imem.sv
module seq_imem #(
    parameter int AW = 7,
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/seq_decode.sv
module seq_decode
    import seq_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              issue,
    output instr_t            instr,
    output logic [NGROUP-1:0] grp_en
);
    always_comb begin
        instr  = split_word(word);
        grp_en = '0;
        if (issue) begin
            unique case (instr.op)
                OP_SW_AMP: grp_en[0] = 1'b1;
                OP_SW_PIX: grp_en[1] = 1'b1;
                OP_SW_AUX: grp_en[2] = 1'b1;
                default:   grp_en    = '0;
            endcase
        end
    end
endmodule

// File: rtl/seq_swbank.sv
module seq_swbank
    import seq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [SWIDX_W-1:0] idx,
    input  logic               val,
    output logic [W-1:0]       q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                q[i] <= 1'b0;
            end else if (en && (idx == SWIDX_W'(i))) begin
                q[i] <= val;
            end
        end
    end
endmodule

// File: rtl/sensor_ctrl_seq.sv
module sensor_ctrl_seq
    import seq_pkg::*;
#(
    parameter int AW   = 7,
    parameter int SW_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic                imem_we,
    input  logic [AW-1:0]       imem_waddr,
    input  logic [WORD_W-1:0]   imem_wdata,
    output logic [BODY_W-1:0]   row_sel,
    output logic [SW_W-1:0]     amp_sw,
    output logic [SW_W-1:0]     pix_sw,
    output logic [SW_W-1:0]     aux_sw,
    output logic                cfg_we,
    output logic [CFG_W-1:0]    cfg_data
);
    logic [AW-1:0]       pc;
    logic [WORD_W-1:0]   word;
    instr_t              instr;
    logic [NGROUP-1:0]   grp_en;
    state_e              state;
    logic [BODY_W-1:0]   pause_cnt;
    logic [BODY_W-1:0]   loop_cnt;
    logic [BODY_W-1:0]   cfg_hi;
    logic                issue;
    logic                in_pause;
    logic [SW_W-1:0]     grp_q [NGROUP];

    assign issue    = run && (state == ST_ISSUE);
    assign in_pause = (state == ST_PAUSE);

    seq_imem #(.AW(AW), .DW(WORD_W)) u_imem (
        .clk   (clk),
        .we    (imem_we),
        .waddr (imem_waddr),
        .wdata (imem_wdata),
        .raddr (pc),
        .rdata (word)
    );

    seq_decode u_dec (
        .word   (word),
        .issue  (issue),
        .instr  (instr),
        .grp_en (grp_en)
    );

    for (genvar g = 0; g < NGROUP; g++) begin : g_grp
        seq_swbank #(.W(SW_W)) u_bank (
            .clk (clk),
            .rst (rst),
            .en  (grp_en[g]),
            .idx (instr.sw_idx),
            .val (instr.sw_val),
            .q   (grp_q[g])
        );
    end

    assign amp_sw = grp_q[0];
    assign pix_sw = grp_q[1];
    assign aux_sw = grp_q[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            pc        <= '0;
            state     <= ST_ISSUE;
            pause_cnt <= '0;
            loop_cnt  <= '0;
            cfg_hi    <= '0;
            row_sel   <= '0;
            cfg_we    <= 1'b0;
            cfg_data  <= '0;
        end else begin
            cfg_we <= 1'b0;
            if (!run) begin
                pc    <= '0;
                state <= ST_ISSUE;
            end else begin
                unique case (state)
                    ST_ISSUE: begin
                        unique case (instr.op)
                            OP_PAUSE: begin
                                if (instr.body == '0) begin
                                    pc <= pc + AW'(1);
                                end else begin
                                    pause_cnt <= instr.body;
                                    state     <= ST_PAUSE;
                                end
                            end
                            OP_ROW: begin
                                row_sel <= instr.body;
                                pc      <= pc + AW'(1);
                            end
                            OP_LOOPSET: begin
                                loop_cnt <= instr.body;
                                pc       <= pc + AW'(1);
                            end
                            OP_LOOPJMP: begin
                                if (loop_cnt != '0) begin
                                    loop_cnt <= loop_cnt - BODY_W'(1);
                                    pc       <= instr.body[AW-1:0];
                                end else begin
                                    pc <= pc + AW'(1);
                                end
                            end
                            OP_CFGWR: begin
                                cfg_hi <= instr.body;
                                pc     <= pc + AW'(1);
                                state  <= ST_CFG2;
                            end
                            default: begin
                                pc <= pc + AW'(1);
                            end
                        endcase
                    end
                    ST_PAUSE: begin
                        pause_cnt <= pause_cnt - BODY_W'(1);
                        if (pause_cnt == BODY_W'(1)) begin
                            pc    <= pc + AW'(1);
                            state <= ST_ISSUE;
                        end
                    end
                    ST_CFG2: begin
                        cfg_data <= {cfg_hi, word};
                        cfg_we   <= 1'b1;
                        pc       <= pc + AW'(1);
                        state    <= ST_ISSUE;
                    end
                    default: state <= ST_ISSUE;
                endcase
            end
        end
    end
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
    parameter int SW_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            run,
    input logic            in_pause,
    input logic [8:0]      row_sel,
    input logic [SW_W-1:0] amp_sw,
    input logic [SW_W-1:0] pix_sw,
    input logic [SW_W-1:0] aux_sw,
    input logic            cfg_we,
    input logic [20:0]     cfg_data
);
    logic [3*SW_W-1:0] all_sw;
    assign all_sw = {amp_sw, pix_sw, aux_sw};

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (row_sel == '0 && all_sw == '0 && !cfg_we && cfg_data == '0)); // R1

    AST_ONE_SWITCH: assert property (@(posedge clk) disable iff (rst)
        $countones(all_sw ^ $past(all_sw)) <= 1); // R4

    AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        in_pause |=> ($stable(row_sel) && $stable(all_sw) && !cfg_we)); // R5

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> !cfg_we); // R7

    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !run |=> ($stable(row_sel) && $stable(all_sw) && !cfg_we)); // R8
endmodule

bind sensor_ctrl_seq seq_checker #(.SW_W(SW_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .in_pause (in_pause),
    .row_sel  (row_sel),
    .amp_sw   (amp_sw),
    .pix_sw   (pix_sw),
    .aux_sw   (aux_sw),
    .cfg_we   (cfg_we),
    .cfg_data (cfg_data)
);

// File: tb/tb_sensor_ctrl_seq.sv
module tb_sensor_ctrl_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        run;
    logic        imem_we;
    logic [6:0]  imem_waddr;
    logic [11:0] imem_wdata;
    logic [8:0]  row_sel;
    logic [7:0]  amp_sw, pix_sw, aux_sw;
    logic        cfg_we;
    logic [20:0] cfg_data;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sensor_ctrl_seq dut (
        .clk(clk), .rst(rst), .run(run),
        .imem_we(imem_we), .imem_waddr(imem_waddr), .imem_wdata(imem_wdata),
        .row_sel(row_sel), .amp_sw(amp_sw), .pix_sw(pix_sw), .aux_sw(aux_sw),
        .cfg_we(cfg_we), .cfg_data(cfg_data)
    );

    // Program: {opcode[11:9], body[8:0]}
    localparam int NPROG = 15;
    localparam logic [11:0] PROG [NPROG] = '{
        12'h205, // 0  row 5                      R3
        12'h405, // 1  amp switch 2 on            R4
        12'h002, // 2  pause 2 (3 cycles)         R5
        12'h601, // 3  pix switch 0 on            R4
        12'h813, // 4  aux switch 9 on: ignored   R4
        12'hA02, // 5  loop load 2                R6
        12'h803, // 6  aux switch 1 on
        12'h802, // 7  aux switch 1 off
        12'hC06, // 8  loop jump to 6             R6
        12'hF55, // 9  register write, high 0x155 R7
        12'hA5C, // 10 register write, low 0xA5C
        12'h3FF, // 11 row 0x1FF                  R3
        12'h000, // 12 pause 0 (1 cycle)          R5
        12'hC0D, // 13 loop jump, counter empty   R6
        12'h404  // 14 amp switch 2 off           R4
    };

    // Expected after each edge: {row[9], amp[8], pix[8], aux[8], we[1]}
    localparam int NEXP = 23;
    localparam logic [33:0] EXP [NEXP] = '{
        {9'h005, 8'h00, 8'h00, 8'h00, 1'b0},
        {9'h005, 8'h04, 8'h00, 8'h00, 1'b0},
        {9'h005, 8'h04, 8'h00, 8'h00, 1'b0},
        {9'h005, 8'h04, 8'h00, 8'h00, 1'b0},
        {9'h005, 8'h04, 8'h00, 8'h00, 1'b0},
        {9'h005, 8'h04, 8'h01, 8'h00, 1'b0},
        {9'h005, 8'h04, 8'h01, 8'h00, 1'b0},
        {9'h005, 8'h04, 8'h01, 8'h00, 1'b0},
        {9'h005, 8'h04, 8'h01, 8'h02, 1'b0},
        {9'h005, 8'h04, 8'h01, 8'h00, 1'b0},
        {9'h005, 8'h04, 8'h01, 8'h00, 1'b0},
        {9'h005, 8'h04, 8'h01, 8'h02, 1'b0},
        {9'h005, 8'h04, 8'h01, 8'h00, 1'b0},
        {9'h005, 8'h04, 8'h01, 8'h00, 1'b0},
        {9'h005, 8'h04, 8'h01, 8'h02, 1'b0},
        {9'h005, 8'h04, 8'h01, 8'h00, 1'b0},
        {9'h005, 8'h04, 8'h01, 8'h00, 1'b0},
        {9'h005, 8'h04, 8'h01, 8'h00, 1'b0},
        {9'h005, 8'h04, 8'h01, 8'h00, 1'b1},
        {9'h1FF, 8'h04, 8'h01, 8'h00, 1'b0},
        {9'h1FF, 8'h04, 8'h01, 8'h00, 1'b0},
        {9'h1FF, 8'h04, 8'h01, 8'h00, 1'b0},
        {9'h1FF, 8'h00, 8'h01, 8'h00, 1'b0}
    };

    function automatic logic [33:0] outs();
        return {row_sel, amp_sw, pix_sw, aux_sw, cfg_we};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; run = 1'b0; imem_we = 1'b0; imem_waddr = '0; imem_wdata = '0;
        @(negedge clk); @(negedge clk);
        check("R1 reset outputs", 64'(outs()), 64'(34'h0));
        check("R1 reset cfg_data", 64'(cfg_data), 64'h0);

        // R9 load whole store through the write port
        for (int a = 0; a < 128; a++) begin
            imem_we = 1'b1;
            imem_waddr = 7'(a);
            imem_wdata = (a < NPROG) ? PROG[a] : 12'h000;
            @(negedge clk);
        end
        imem_we = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R8 idle while run low", 64'(outs()), 64'(34'h0));

        // Main trace: R2 R3 R4 R5 R6 R7
        run = 1'b1;
        for (int k = 0; k < NEXP; k++) begin
            @(negedge clk);
            check($sformatf("R2 trace cycle %0d", k), 64'(outs()), 64'(EXP[k]));
            if (k == 18) check("R7 cfg_data value", 64'(cfg_data), 64'h155A5C);
        end
        check("R7 cfg_data held after strobe", 64'(cfg_data), 64'h155A5C);

        // R8 stop: outputs hold, rewind to 0
        run = 1'b0;
        // R9 patch word 1 while stopped: pix switch 0 off
        imem_we = 1'b1; imem_waddr = 7'd1; imem_wdata = 12'h600;
        @(negedge clk);
        imem_we = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 outputs hold while stopped", 64'(outs()),
              64'({9'h1FF, 8'h00, 8'h01, 8'h00, 1'b0}));
        run = 1'b1;
        @(negedge clk);
        check("R8 restart from address 0", 64'(row_sel), 64'h005);
        @(negedge clk);
        check("R9 patched word executes", 64'(pix_sw), 64'h00);
        check("R4 other groups unchanged", 64'({amp_sw, aux_sw}), 64'h0);

        // R1 mid-run reset
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset", 64'(outs()), 64'(34'h0));
        check("R1 mid-run reset cfg_data", 64'(cfg_data), 64'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R3 row after reset restart", 64'(row_sel), 64'h005);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule